// File: doc/BRIEF.md
# Dual-Edge GPIO Interrupt and Wake Unit

This unit watches a bank of asynchronous general-purpose input pins, brings each one into the clock domain through a short synchroniser chain, and finds its rising and falling edges by comparing the synchronised value with the value from one cycle earlier. Each pin can count rising edges, falling edges, or both toward a normal interrupt. A second, independent pair of per-pin enables decides which edges count toward a wake-up request.

Qualifying edges set sticky per-pin pending bits. There is one pending bank for interrupts and one for wake. Software reads a pending bank, services the pins it finds (usually the lowest set bit first), and acknowledges them by writing ones to the same select code. The unit drives a single combined interrupt line to a parent controller and a single combined wake request. Both stay asserted as long as any bit in their bank is pending.

Configuration uses a plain synchronous write port and a combinational read port, each addressed by a 3-bit select code.

Top module: `gpio_edge_irq_wake`

## Requirements
- R1: After reset, both pending banks read 0 and `irq_out` and `wake_out` are low. The rising interrupt enables and both wake enables read 0. The falling interrupt enable reads all ones, so the default trigger is falling edge only.
- R2: A 0-to-1 change on a pin whose rising interrupt enable is set makes its interrupt pending bit read 1. This happens at the (SYNC_STAGES+1)-th rising clock edge after the pin changes.
- R3: A 1-to-0 change on a pin whose falling interrupt enable is set makes its pending bit read 1 with the same latency. A pin with both enables set counts both edges.
- R4: An edge whose polarity is not enabled for its pin leaves that pin's pending bit unchanged.
- R5: A write to select 4 clears every interrupt pending bit where the write data is 1. Bits where the data is 0 keep their value.
- R6: If a clear write and a new enabled edge hit the same pending bit in the same cycle, the bit stays 1.
- R7: `irq_out` is 1 exactly while at least one interrupt pending bit is 1.
- R8: Wake pending bits are set only through the wake enables (rising: select 2, falling: select 3). The interrupt enables have no effect on wake pending, and the wake enables have no effect on interrupt pending.
- R9: `wake_out` stays 1 while any wake pending bit is 1. It is unaffected by interrupt clears and drops only when a write to select 5 clears the last wake pending bit.
- R10: Select codes are as follows. 0 is the rising interrupt enable, 1 the falling interrupt enable, 2 the rising wake enable and 3 the falling wake enable; all four are writable and read back the last value written. 4 reads interrupt pending, and a write to it clears. 5 reads wake pending, and a write to it clears. Codes 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPIN | Asynchronous pin levels |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write select code |
| wr_data | input | NPIN | Write data, one bit per pin |
| rd_sel | input | 3 | Read select code |
| rd_data | output | NPIN | Combinational read data |
| irq_out | output | 1 | Combined interrupt to the parent controller |
| wake_out | output | 1 | Combined wake request |

## Verification
The bench builds the unit with NPIN = 8 and SYNC_STAGES = 2. At that size it can walk every pin through all four rising/falling enable combinations while all eight pins toggle together, so each edge that is not enabled is shown to be ignored. The two-stage chain fixes the capture latency at three edges, and the bench uses that to line up a clear write with a new edge in the same cycle. Separate passes keep the interrupt enables at zero while exercising the wake enables, and the reverse, to show the two paths are independent.

// File: rtl/gpio_ew_pkg.sv
package gpio_ew_pkg;

    localparam int SEL_W    = 3;
    localparam int MASK_CNT = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_RISE_IRQ  = 3'd0,
        SEL_FALL_IRQ  = 3'd1,
        SEL_RISE_WAKE = 3'd2,
        SEL_FALL_WAKE = 3'd3,
        SEL_IRQ_STAT  = 3'd4,
        SEL_WAKE_STAT = 3'd5
    } reg_sel_e;

    // One pin's edge events, or one pin's edge enables
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    function automatic logic edge_hit(edge_pair_t ev, edge_pair_t en);
        return (ev.rise & en.rise) | (ev.fall & en.fall);
    endfunction

    // Reset value of an enable register: falling-edge interrupts default on
    function automatic logic mask_reset_bit(int idx);
        return idx == int'(SEL_FALL_IRQ);
    endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync
    import gpio_ew_pkg::*;
#(
    parameter int NPIN        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] rise_o,
    output logic [NPIN-1:0] fall_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [NPIN-1:0] chain [SYNC_STAGES];
    logic [NPIN-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_STAGES; s++) chain[s] <= '0;
            prev_q <= '0;
        end else begin
            chain[0] <= pin_i;
            for (int s = 1; s < SYNC_STAGES; s++) chain[s] <= chain[s-1];
            prev_q <= chain[LAST];
        end
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        edge_pair_t ev;
        assign ev.rise  = chain[LAST][i] & ~prev_q[i];
        assign ev.fall  = ~chain[LAST][i] & prev_q[i];
        assign rise_o[i] = ev.rise;
        assign fall_o[i] = ev.fall;
    end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_ew_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [NPIN-1:0]  wr_data,
    output logic [NPIN-1:0]  rise_irq_o,
    output logic [NPIN-1:0]  fall_irq_o,
    output logic [NPIN-1:0]  rise_wake_o,
    output logic [NPIN-1:0]  fall_wake_o
);
    logic [NPIN-1:0] mask_q [MASK_CNT];

    for (genvar k = 0; k < MASK_CNT; k++) begin : g_mask
        localparam logic RST_BIT = mask_reset_bit(k);
        logic hit_sel;
        assign hit_sel = wr_en && (wr_sel == SEL_W'(k));

        always_ff @(posedge clk) begin
            if (rst)          mask_q[k] <= {NPIN{RST_BIT}};
            else if (hit_sel) mask_q[k] <= wr_data;
        end

        // R10: an enable register keeps its value in cycles without a write
        a_r10_mask_hold: assert property (@(posedge clk) disable iff (rst)
            !wr_en |=> $stable(mask_q[k]));
    end

    assign rise_irq_o  = mask_q[SEL_RISE_IRQ];
    assign fall_irq_o  = mask_q[SEL_FALL_IRQ];
    assign rise_wake_o = mask_q[SEL_RISE_WAKE];
    assign fall_wake_o = mask_q[SEL_FALL_WAKE];

endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank
    import gpio_ew_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] rise_i,
    input  logic [NPIN-1:0] fall_i,
    input  logic [NPIN-1:0] rmask_i,
    input  logic [NPIN-1:0] fmask_i,
    input  logic            clr_en_i,
    input  logic [NPIN-1:0] clr_data_i,
    output logic [NPIN-1:0] pend_o,
    output logic [NPIN-1:0] hit_o
);
    logic [NPIN-1:0] pend_q;
    logic [NPIN-1:0] clr_mask;

    assign clr_mask = clr_en_i ? clr_data_i : '0;

    for (genvar i = 0; i < NPIN; i++) begin : g_hit
        edge_pair_t ev;
        edge_pair_t en;
        assign ev.rise = rise_i[i];
        assign ev.fall = fall_i[i];
        assign en.rise = rmask_i[i];
        assign en.fall = fmask_i[i];
        assign hit_o[i] = edge_hit(ev, en);
    end

    // A new hit wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_mask) | hit_o;
    end

    assign pend_o = pend_q;

    // R2: a pending bit rises only after a qualifying edge
    a_r2_set_cause: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pend_q & ~$past(pend_q)) & ~$past(hit_o)) == '0));

    // R5: a cleared bit with no simultaneous hit reads 0 afterwards
    a_r5_clear_effect: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(clr_mask) & ~$past(hit_o)) & pend_q) == '0));

    // R6: a pending bit not cleared stays set (sticky)
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(pend_q) & ~$past(clr_mask)) & ~pend_q) == '0));

endmodule

// File: rtl/gpio_edge_irq_wake.sv
module gpio_edge_irq_wake
    import gpio_ew_pkg::*;
#(
    parameter int NPIN        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPIN-1:0]  pin_in,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [NPIN-1:0]  wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [NPIN-1:0]  rd_data,
    output logic             irq_out,
    output logic             wake_out
);
    logic [NPIN-1:0] rise, fall;
    logic [NPIN-1:0] rise_irq, fall_irq, rise_wake, fall_wake;
    logic [NPIN-1:0] irq_pend, wake_pend, irq_hit, wake_hit;
    logic            irq_clr, wake_clr;

    gpio_edge_sync #(.NPIN(NPIN), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_i(pin_in), .rise_o(rise), .fall_o(fall)
    );

    gpio_cfg_regs #(.NPIN(NPIN)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rise_irq_o(rise_irq), .fall_irq_o(fall_irq),
        .rise_wake_o(rise_wake), .fall_wake_o(fall_wake)
    );

    assign irq_clr  = wr_en && (wr_sel == SEL_IRQ_STAT);
    assign wake_clr = wr_en && (wr_sel == SEL_WAKE_STAT);

    gpio_pend_bank #(.NPIN(NPIN)) u_irq_bank (
        .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall),
        .rmask_i(rise_irq), .fmask_i(fall_irq),
        .clr_en_i(irq_clr), .clr_data_i(wr_data),
        .pend_o(irq_pend), .hit_o(irq_hit)
    );

    gpio_pend_bank #(.NPIN(NPIN)) u_wake_bank (
        .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall),
        .rmask_i(rise_wake), .fmask_i(fall_wake),
        .clr_en_i(wake_clr), .clr_data_i(wr_data),
        .pend_o(wake_pend), .hit_o(wake_hit)
    );

    assign irq_out  = |irq_pend;
    assign wake_out = |wake_pend;

    always_comb begin
        case (rd_sel)
            SEL_RISE_IRQ:  rd_data = rise_irq;
            SEL_FALL_IRQ:  rd_data = fall_irq;
            SEL_RISE_WAKE: rd_data = rise_wake;
            SEL_FALL_WAKE: rd_data = fall_wake;
            SEL_IRQ_STAT:  rd_data = irq_pend;
            SEL_WAKE_STAT: rd_data = wake_pend;
            default:       rd_data = '0;
        endcase
    end

    // R9: the wake request rises only after a wake-enabled edge
    a_r9_wake_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_out) |-> $past(|wake_hit));

    // R9: the wake request holds unless a wake clear was written
    a_r9_wake_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(wake_out) |-> $past(wake_clr));

    // R7: the interrupt line falls only through an interrupt clear
    a_r7_irq_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_out) |-> $past(irq_clr));

endmodule

// File: tb/test_gpio_edge_irq_wake.sv
module test_gpio_edge_irq_wake;
    localparam int  N      = 8;
    localparam int  SYNC   = 2;
    localparam int  LAT    = SYNC + 1;
    localparam time PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin_in = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_sel = '0;
    logic [N-1:0] wr_data = '0;
    logic [2:0]   rd_sel = '0;
    logic [N-1:0] rd_data;
    logic         irq_out, wake_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    gpio_edge_irq_wake #(.NPIN(N), .SYNC_STAGES(SYNC)) i_gpio_edge_irq_wake (
        .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_out(irq_out), .wake_out(wake_out)
    );

    task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [N-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [N-1:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic drive(input logic [N-1:0] v);
        pin_in = v;
        repeat (LAT) @(negedge clk);
    endtask

    initial begin
        logic [N-1:0] v;
        logic [N-1:0] exp_s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 rise irq en", v, '0);
        rd(3'd1, v); check("R1 fall irq en", v, '1);
        rd(3'd2, v); check("R1 rise wake en", v, '0);
        rd(3'd3, v); check("R1 fall wake en", v, '0);
        rd(3'd4, v); check("R1 irq pend", v, '0);
        rd(3'd5, v); check("R1 wake pend", v, '0);
        check("R1 irq_out", N'(irq_out), '0);
        check("R1 wake_out", N'(wake_out), '0);

        // R10 readback and unused codes
        for (int k = 0; k < 4; k++) wr(3'(k), N'(8'h35 + 8'(k * 17)));
        for (int k = 0; k < 4; k++) begin
            rd(3'(k), v); check("R10 readback", v, N'(8'h35 + 8'(k * 17)));
        end
        wr(3'd6, '1);
        wr(3'd7, '1);
        rd(3'd6, v); check("R10 code6 reads 0", v, '0);
        rd(3'd7, v); check("R10 code7 reads 0", v, '0);
        for (int k = 0; k < 4; k++) begin
            rd(3'(k), v); check("R10 ignored write", v, N'(8'h35 + 8'(k * 17)));
        end
        wr(3'd2, '0); wr(3'd3, '0);

        // R2 R3 R4 R8 sweep: per pin, all four enable combinations, all pins toggle
        for (int rm = 0; rm < 2; rm++) begin
            for (int fm = 0; fm < 2; fm++) begin
                for (int p = 0; p < N; p++) begin
                    wr(3'd0, rm[0] ? (N'(1) << p) : '0);
                    wr(3'd1, fm[0] ? (N'(1) << p) : '0);
                    wr(3'd4, '1);
                    drive('1);
                    exp_s = rm[0] ? (N'(1) << p) : '0;
                    rd(3'd4, v); check("R2 R4 after rise", v, exp_s);
                    check("R7 irq after rise", N'(irq_out), N'(rm[0]));
                    drive('0);
                    exp_s = (rm[0] | fm[0]) ? (N'(1) << p) : '0;
                    rd(3'd4, v); check("R3 R4 after fall", v, exp_s);
                    rd(3'd5, v); check("R8 no wake from irq en", v, '0);
                    check("R8 wake_out low", N'(wake_out), '0);
                end
            end
        end

        // R3 both edges: rising pending cleared, falling re-sets it
        wr(3'd0, 8'h01); wr(3'd1, 8'h01); wr(3'd4, '1);
        drive(8'h01);
        wr(3'd4, 8'h01);
        rd(3'd4, v); check("R5 cleared before fall", v, '0);
        drive(8'h00);
        rd(3'd4, v); check("R3 both edges fall sets", v, 8'h01);

        // R5 partial clears, R7 line follows
        wr(3'd0, '1); wr(3'd1, '0); wr(3'd4, '1);
        drive('1);
        rd(3'd4, v); check("R2 all rise", v, '1);
        wr(3'd4, 8'h0F);
        rd(3'd4, v); check("R5 partial clear", v, 8'hF0);
        wr(3'd4, 8'h00);
        rd(3'd4, v); check("R5 zero clear no effect", v, 8'hF0);
        check("R7 irq high", N'(irq_out), 1);
        wr(3'd4, 8'h70);
        check("R7 irq still high", N'(irq_out), 1);
        wr(3'd4, 8'h80);
        rd(3'd4, v); check("R5 all cleared", v, '0);
        check("R7 irq low", N'(irq_out), 0);
        drive('0);

        // R6 clear and new edge on same bit in same cycle
        wr(3'd0, 8'h02); wr(3'd1, 8'h02);
        drive(8'h02);
        rd(3'd4, v); check("R6 setup", v, 8'h02);
        pin_in = 8'h00;
        repeat (SYNC) @(negedge clk);
        wr(3'd4, 8'h02);
        rd(3'd4, v); check("R6 hit beats clear", v, 8'h02);
        wr(3'd4, 8'h02);
        rd(3'd4, v); check("R6 later clear", v, '0);

        // R8 R9 wake path with interrupt enables off
        wr(3'd0, '0); wr(3'd1, '0);
        wr(3'd2, 8'h03); wr(3'd3, 8'h40);
        drive('1);
        rd(3'd5, v); check("R8 wake rise", v, 8'h03);
        rd(3'd4, v); check("R8 irq untouched", v, '0);
        check("R9 wake_out high", N'(wake_out), 1);
        check("R8 irq_out low", N'(irq_out), 0);
        wr(3'd4, '1);
        repeat (5) @(negedge clk);
        check("R9 wake held", N'(wake_out), 1);
        drive('0);
        rd(3'd5, v); check("R8 wake fall", v, 8'h43);
        wr(3'd5, 8'h41);
        rd(3'd5, v); check("R9 partial wake clear", v, 8'h02);
        check("R9 wake still high", N'(wake_out), 1);
        wr(3'd5, 8'h02);
        check("R9 wake low", N'(wake_out), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule